// File: doc/BRIEF.md
# Asynchronous Static RAM Access Controller

This block sits between a synchronous request port and an external asynchronous static RAM of 64K words by 16 bits. Each accepted request is a single read or a single write of one word. The block converts the request into the active-low strobe sequence that the RAM needs. These strobes are chip select, write strobe, output enable and two byte-lane strobes. Every analog timing limit of the RAM is turned into a whole number of system clock cycles. The conversion uses a clock-period parameter and a speed-grade parameter. Each limit is rounded up and given a margin cycle.

The data bus leaves the block already split into an output word, an output-drive enable and an input word, so the pad ring holds the tri-state buffer. A byte mask picks which 8-bit lanes take part in each access. On reads, lanes that are not selected come back as zero. Writes touch only the selected lanes. When a write follows a read, the controller keeps its drivers off until the RAM has had time to release the bus.

Top module: `sram_async_ctrl`

## Requirements
- R1: After reset and whenever idle, chip select, write strobe, output enable and both lane strobes are high (inactive), the data drive enable is low, `req_ready` is high and `rsp_valid` is low.
- R2: `req_ready` is high only in the idle state. A request is accepted at a clock edge where `req_valid` and `req_ready` are both high, and `req_ready` is low in the following cycle.
- R3: A read holds chip select low, output enable low and write strobe high for exactly RD_CYC consecutive cycles. The lower lane strobe is low when mask bit 0 is set, and the upper lane strobe is low when mask bit 1 is set. RD_CYC is the maximum of the cycle counts for read cycle, address access and output-enable access (7 at 10 ns clock and the 55 ns grade).
- R4: `rsp_valid` is high for exactly one cycle, namely the first cycle after the last read-strobe cycle. `rsp_rdata` holds the RAM input word sampled in that last cycle. Bits 7:0 are forced to zero when mask bit 0 is clear, and bits 15:8 are forced to zero when mask bit 1 is clear.
- R5: A write holds the write strobe low for exactly WP_CYC consecutive cycles, with chip select low and the lane strobes following the mask. WP_CYC is the maximum of the write-pulse count, the data-setup count and the write-cycle count minus two (5 at 10 ns and the 55 ns grade).
- R6: The RAM address changes only while the write strobe is high, and it stays stable while the write strobe is low.
- R7: The data drive enable is high, and the output word equals the request data, in every cycle with the write strobe low and in the one cycle after the write strobe rises.
- R8: The data drive enable is never high while output enable is low. After output enable rises, the drive enable stays low for OHZ_CYC cycles (3 at 10 ns and the 55 ns grade). A write issued in the cycle where output enable rises first drives data 3 cycles after that cycle. A write that does not follow a read drives data in the cycle after acceptance.
- R9: With the 70 ns grade selected, the counts become RD_CYC = 8 and WP_CYC = 6 at a 10 ns clock.
- R10: A `req_valid` raised while the block is busy is ignored. The running access keeps its address and strobes, and no further access starts after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller idle, request can be accepted |
| req_we | input | 1 | 1 = write, 0 = read |
| req_addr | input | AW | Word address |
| req_wdata | input | 16 | Write data |
| req_bmask | input | 2 | Lane select: bit 0 = bits 7:0, bit 1 = bits 15:8 |
| rsp_valid | output | 1 | One-cycle read-data strobe |
| rsp_rdata | output | 16 | Read data, unselected lanes zero |
| mem_addr | output | AW | RAM address |
| mem_ce_n | output | 1 | RAM chip select, active low |
| mem_we_n | output | 1 | RAM write strobe, active low |
| mem_oe_n | output | 1 | RAM output enable, active low |
| mem_lb_n | output | 1 | RAM lower-lane strobe, active low |
| mem_ub_n | output | 1 | RAM upper-lane strobe, active low |
| mem_dq_out | output | 16 | Data toward the RAM |
| mem_dq_oe | output | 1 | Drive enable for mem_dq_out |
| mem_dq_in | input | 16 | Data from the RAM |

## Verification
Two events can land in the same idle cycle: the end of a read and the acceptance of a write. In that cycle, output enable rises, read data is delivered and the next write is taken. The bench provokes this by issuing a write in exactly the cycle where `rsp_valid` is seen. It then counts the cycles until the drive enable first rises, and that count must equal the computed turnaround. A separate write after an idle period must drive data after one cycle, which shows that the wait comes from the read and not from a fixed delay.

// File: rtl/sram_ctrl_pkg.sv
package sram_ctrl_pkg;

  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_RD   = 3'd1,
    ST_WSET = 3'd2,
    ST_WPUL = 3'd3,
    ST_WHLD = 3'd4
  } ctrl_state_e;

  typedef enum int {
    TI_WC, TI_WP, TI_DW, TI_RC, TI_AA, TI_OE, TI_OHZ
  } tsel_e;

  localparam int DATA_W = 16;
  localparam int LANES  = 2;

  // RAM limit in ns for a speed grade (55 or 70)
  function automatic int grade_ns(input int grade, input tsel_e sel);
    int v;
    v = 0;
    if (grade == 70) begin
      case (sel)
        TI_WC:  v = 70;
        TI_WP:  v = 45;
        TI_DW:  v = 30;
        TI_RC:  v = 70;
        TI_AA:  v = 70;
        TI_OE:  v = 35;
        TI_OHZ: v = 25;
        default: v = 70;
      endcase
    end else begin
      case (sel)
        TI_WC:  v = 55;
        TI_WP:  v = 35;
        TI_DW:  v = 25;
        TI_RC:  v = 55;
        TI_AA:  v = 55;
        TI_OE:  v = 25;
        TI_OHZ: v = 20;
        default: v = 55;
      endcase
    end
    return v;
  endfunction

  // ceil(ns / clk) plus safety margin
  function automatic int ns2cyc(input int ns, input int clk_ns, input int margin);
    return (ns + clk_ns - 1) / clk_ns + margin;
  endfunction

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  function automatic int lim_cyc(input int grade, input tsel_e sel,
                                 input int clk_ns, input int margin);
    return ns2cyc(grade_ns(grade, sel), clk_ns, margin);
  endfunction

endpackage

// File: rtl/sram_wait_cnt.sv
module sram_wait_cnt #(
  parameter int CW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  output logic          done
);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               cnt_q <= '0;
    else if (load)            cnt_q <= load_val;
    else if (cnt_q != '0)     cnt_q <= cnt_q - 1'b1;
  end

  assign done = (cnt_q == '0);
endmodule

// File: rtl/sram_bus_guard.sv
module sram_bus_guard #(
  parameter int OHZ_CYC = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic oe_n,
  output logic bus_free
);
  localparam int GW = $clog2(OHZ_CYC + 1) + 1;
  localparam logic [GW-1:0] GAP_LD = GW'(OHZ_CYC - 1);

  logic          oe_n_q;
  logic [GW-1:0] gap_q;
  logic          oe_rise;

  assign oe_rise = oe_n & ~oe_n_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      oe_n_q <= 1'b1;
      gap_q  <= '0;
    end else begin
      oe_n_q <= oe_n;
      if (oe_rise)            gap_q <= GAP_LD;
      else if (gap_q != '0)   gap_q <= gap_q - 1'b1;
    end
  end

  assign bus_free = oe_n & ~oe_rise & (gap_q == '0);
endmodule

// File: rtl/sram_ctrl_fsm.sv
module sram_ctrl_fsm
  import sram_ctrl_pkg::*;
#(
  parameter int AW     = 16,
  parameter int CW     = 4,
  parameter int RD_CYC = 7,
  parameter int WP_CYC = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_we,
  input  logic [AW-1:0]     req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic [LANES-1:0]  req_bmask,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata,
  input  logic              bus_free,
  input  logic              cnt_done,
  output logic              cnt_load,
  output logic [CW-1:0]     cnt_val,
  output logic              rd_capture,
  output logic [AW-1:0]     mem_addr,
  output logic              mem_ce_n,
  output logic              mem_we_n,
  output logic              mem_oe_n,
  output logic              mem_lb_n,
  output logic              mem_ub_n,
  output logic [DATA_W-1:0] mem_dq_out,
  output logic              mem_dq_oe,
  input  logic [DATA_W-1:0] mem_dq_in
);
  localparam logic [CW-1:0] RD_LD = CW'(RD_CYC - 1);
  localparam logic [CW-1:0] WP_LD = CW'(WP_CYC - 1);

  ctrl_state_e       st_q, st_d;
  logic [AW-1:0]     addr_q;
  logic [DATA_W-1:0] wdata_q, rdata_q;
  logic [LANES-1:0]  bmask_q;
  logic              rvalid_q;
  logic              accept;
  logic [DATA_W-1:0] lane_keep;

  assign req_ready = (st_q == ST_IDLE);
  assign accept    = req_valid & req_ready;

  always_comb begin
    st_d     = st_q;
    cnt_load = 1'b0;
    cnt_val  = RD_LD;
    case (st_q)
      ST_IDLE: if (req_valid) begin
        if (req_we) st_d = ST_WSET;
        else begin
          st_d     = ST_RD;
          cnt_load = 1'b1;
          cnt_val  = RD_LD;
        end
      end
      ST_RD:   if (cnt_done) st_d = ST_IDLE;
      ST_WSET: if (bus_free) begin
        st_d     = ST_WPUL;
        cnt_load = 1'b1;
        cnt_val  = WP_LD;
      end
      ST_WPUL: if (cnt_done) st_d = ST_WHLD;
      ST_WHLD: st_d = ST_IDLE;
      default: st_d = ST_IDLE;
    endcase
  end

  assign rd_capture = (st_q == ST_RD) & cnt_done;

  genvar g;
  generate
    for (g = 0; g < LANES; g++) begin : g_lane
      assign lane_keep[g*8 +: 8] = {8{bmask_q[g]}};
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q     <= ST_IDLE;
      addr_q   <= '0;
      wdata_q  <= '0;
      bmask_q  <= '0;
      rdata_q  <= '0;
      rvalid_q <= 1'b0;
    end else begin
      st_q     <= st_d;
      rvalid_q <= rd_capture;
      if (accept) begin
        addr_q  <= req_addr;
        wdata_q <= req_wdata;
        bmask_q <= req_bmask;
      end
      if (rd_capture) rdata_q <= mem_dq_in & lane_keep;
    end
  end

  assign mem_addr   = addr_q;
  assign mem_ce_n   = !((st_q == ST_RD) || (st_q == ST_WSET) || (st_q == ST_WPUL));
  assign mem_oe_n   = (st_q != ST_RD);
  assign mem_we_n   = (st_q != ST_WPUL);
  assign mem_lb_n   = mem_ce_n | ~bmask_q[0];
  assign mem_ub_n   = mem_ce_n | ~bmask_q[1];
  assign mem_dq_out = wdata_q;
  assign mem_dq_oe  = ((st_q == ST_WSET) & bus_free) | (st_q == ST_WPUL) | (st_q == ST_WHLD);
  assign rsp_valid  = rvalid_q;
  assign rsp_rdata  = rdata_q;
endmodule

// File: rtl/sram_async_ctrl.sv
module sram_async_ctrl
  import sram_ctrl_pkg::*;
#(
  parameter int AW          = 16,
  parameter int CLK_NS      = 10,
  parameter int SPEED_GRADE = 55,
  parameter int MARGIN      = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_we,
  input  logic [AW-1:0]     req_addr,
  input  logic [15:0]       req_wdata,
  input  logic [1:0]        req_bmask,
  output logic              rsp_valid,
  output logic [15:0]       rsp_rdata,
  output logic [AW-1:0]     mem_addr,
  output logic              mem_ce_n,
  output logic              mem_we_n,
  output logic              mem_oe_n,
  output logic              mem_lb_n,
  output logic              mem_ub_n,
  output logic [15:0]       mem_dq_out,
  output logic              mem_dq_oe,
  input  logic [15:0]       mem_dq_in
);
  localparam int RD_CYC = imax(imax(lim_cyc(SPEED_GRADE, TI_AA, CLK_NS, MARGIN),
                                    lim_cyc(SPEED_GRADE, TI_OE, CLK_NS, MARGIN)),
                               lim_cyc(SPEED_GRADE, TI_RC, CLK_NS, MARGIN));
  localparam int WP_CYC = imax(imax(lim_cyc(SPEED_GRADE, TI_WP, CLK_NS, MARGIN),
                                    lim_cyc(SPEED_GRADE, TI_DW, CLK_NS, MARGIN)),
                               lim_cyc(SPEED_GRADE, TI_WC, CLK_NS, MARGIN) - 2);
  localparam int OHZ_CYC = lim_cyc(SPEED_GRADE, TI_OHZ, CLK_NS, MARGIN);
  localparam int CW      = $clog2(imax(RD_CYC, WP_CYC) + 1) + 1;

  // named internal events
  logic          bus_free;
  logic          cnt_done;
  logic          cnt_load;
  logic [CW-1:0] cnt_val;
  logic          rd_capture;

  sram_wait_cnt #(.CW(CW)) u_cnt (
    .clk(clk), .rst_n(rst_n), .load(cnt_load), .load_val(cnt_val), .done(cnt_done)
  );

  sram_bus_guard #(.OHZ_CYC(OHZ_CYC)) u_guard (
    .clk(clk), .rst_n(rst_n), .oe_n(mem_oe_n), .bus_free(bus_free)
  );

  sram_ctrl_fsm #(.AW(AW), .CW(CW), .RD_CYC(RD_CYC), .WP_CYC(WP_CYC)) u_fsm (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_we(req_we),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_bmask(req_bmask),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .bus_free(bus_free), .cnt_done(cnt_done), .cnt_load(cnt_load), .cnt_val(cnt_val),
    .rd_capture(rd_capture),
    .mem_addr(mem_addr), .mem_ce_n(mem_ce_n), .mem_we_n(mem_we_n), .mem_oe_n(mem_oe_n),
    .mem_lb_n(mem_lb_n), .mem_ub_n(mem_ub_n), .mem_dq_out(mem_dq_out),
    .mem_dq_oe(mem_dq_oe), .mem_dq_in(mem_dq_in)
  );
endmodule

// File: rtl/sram_ctrl_chk.sv
module sram_ctrl_chk #(
  parameter int AW     = 16,
  parameter int WP_CYC = 5
) (
  input logic          clk,
  input logic          rst_n,
  input logic          req_ready,
  input logic          rsp_valid,
  input logic          rd_capture,
  input logic [AW-1:0] mem_addr,
  input logic          mem_ce_n,
  input logic          mem_we_n,
  input logic          mem_oe_n,
  input logic          mem_lb_n,
  input logic          mem_ub_n,
  input logic          mem_dq_oe
);
  logic [15:0] low_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          low_cnt <= '0;
    else if (!mem_we_n)  low_cnt <= (low_cnt == 16'hFFFF) ? low_cnt : low_cnt + 16'd1;
    else                 low_cnt <= '0;
  end

  a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (mem_ce_n && mem_we_n && mem_oe_n && mem_lb_n && mem_ub_n && !mem_dq_oe));

  a_r3_read_strobes: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_oe_n |-> (mem_we_n && !mem_ce_n));

  a_r4_one_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);

  a_r4_after_capture: assert property (@(posedge clk) disable iff (!rst_n)
    rd_capture |=> rsp_valid);

  a_r5_ce_covers_we: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_we_n |-> !mem_ce_n);

  a_r5_pulse_len: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_we_n) |-> (low_cnt >= 16'(WP_CYC)));

  a_r6_addr_stable: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_we_n |-> $stable(mem_addr));

  a_r7_data_hold: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_we_n) |-> (mem_dq_oe && $past(mem_dq_oe)));

  a_r8_no_contention: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_oe_n |-> !mem_dq_oe);

  a_r8_gap_after_oe: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_oe_n) |=> !mem_dq_oe);
endmodule

bind sram_async_ctrl sram_ctrl_chk #(.AW(AW), .WP_CYC(WP_CYC)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_ready(req_ready), .rsp_valid(rsp_valid),
  .rd_capture(rd_capture), .mem_addr(mem_addr), .mem_ce_n(mem_ce_n),
  .mem_we_n(mem_we_n), .mem_oe_n(mem_oe_n), .mem_lb_n(mem_lb_n),
  .mem_ub_n(mem_ub_n), .mem_dq_oe(mem_dq_oe)
);

// File: tb/tb_sram_async_ctrl.sv
`timescale 1ns/1ps
module tb_sram_async_ctrl;
  localparam int CLK_P = 10;

  function automatic int up(input int ns);
    return ns / CLK_P + ((ns % CLK_P) != 0 ? 1 : 0) + 1;
  endfunction
  function automatic int mx(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  localparam int E_RD55  = mx(mx(up(55), up(25)), up(55));
  localparam int E_WP55  = mx(mx(up(35), up(25)), up(55) - 2);
  localparam int E_OHZ55 = up(20);
  localparam int E_RD70  = mx(mx(up(70), up(35)), up(70));
  localparam int E_WP70  = mx(mx(up(45), up(30)), up(70) - 2);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #(CLK_P/2) clk = ~clk;

  logic        req_valid = 1'b0, req_we = 1'b0;
  logic [15:0] req_addr = '0, req_wdata = '0;
  logic [1:0]  req_bmask = '0;
  logic        req_ready, rsp_valid;
  logic [15:0] rsp_rdata, mem_addr, mem_dq_out, mem_dq_in;
  logic        mem_ce_n, mem_we_n, mem_oe_n, mem_lb_n, mem_ub_n, mem_dq_oe;

  function automatic logic [15:0] pat(input logic [15:0] a);
    return {a[7:0], a[15:8]} ^ 16'h3C96;
  endfunction

  logic [15:0] pv;
  assign pv = pat(mem_addr);
  assign mem_dq_in = (!mem_ce_n && !mem_oe_n) ?
                     {(mem_ub_n ? 8'hEE : pv[15:8]), (mem_lb_n ? 8'hEE : pv[7:0])} : 16'hFFFF;

  sram_async_ctrl #(.AW(16), .CLK_NS(CLK_P), .SPEED_GRADE(55), .MARGIN(1)) dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_we(req_we), .req_addr(req_addr), .req_wdata(req_wdata), .req_bmask(req_bmask),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .mem_addr(mem_addr),
    .mem_ce_n(mem_ce_n), .mem_we_n(mem_we_n), .mem_oe_n(mem_oe_n),
    .mem_lb_n(mem_lb_n), .mem_ub_n(mem_ub_n), .mem_dq_out(mem_dq_out),
    .mem_dq_oe(mem_dq_oe), .mem_dq_in(mem_dq_in)
  );

  // second instance, slower grade
  logic        v70 = 1'b0, we70 = 1'b0;
  logic        rdy70, rv70, ce70, wen70, oe70, lb70, ub70, dqoe70;
  logic [15:0] rd70, ad70, dqo70;
  sram_async_ctrl #(.AW(16), .CLK_NS(CLK_P), .SPEED_GRADE(70), .MARGIN(1)) dut70 (
    .clk(clk), .rst_n(rst_n), .req_valid(v70), .req_ready(rdy70),
    .req_we(we70), .req_addr(16'h0042), .req_wdata(16'hBEEF), .req_bmask(2'b11),
    .rsp_valid(rv70), .rsp_rdata(rd70), .mem_addr(ad70),
    .mem_ce_n(ce70), .mem_we_n(wen70), .mem_oe_n(oe70),
    .mem_lb_n(lb70), .mem_ub_n(ub70), .mem_dq_out(dqo70),
    .mem_dq_oe(dqoe70), .mem_dq_in(16'h0000)
  );

  int n_chk = 0, n_bad = 0;
  bit finished = 1'b0;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic t_reset();
    chk(req_ready == 1'b1, "R1", "ready after reset", req_ready, 1);
    chk({mem_ce_n, mem_we_n, mem_oe_n, mem_lb_n, mem_ub_n} == 5'b11111, "R1",
        "strobes idle", {mem_ce_n, mem_we_n, mem_oe_n, mem_lb_n, mem_ub_n}, 5'b11111);
    chk(!mem_dq_oe && !rsp_valid, "R1", "drive/valid idle", {mem_dq_oe, rsp_valid}, 0);
  endtask

  // ends on the falling edge where rsp_valid is seen
  task automatic do_read(input logic [15:0] a, input logic [1:0] m, input bit poke);
    int rd = 0, k = 0;
    logic [15:0] e;
    chk(req_ready, "R2", "ready before read", req_ready, 1);
    req_valid = 1'b1; req_we = 1'b0; req_addr = a; req_bmask = m;
    @(negedge clk);
    req_valid = 1'b0;
    chk(!req_ready, "R2", "ready low after accept", req_ready, 0);
    chk(!rsp_valid, "R4", "no early valid", rsp_valid, 0);
    while (!rsp_valid && k < 100) begin
      if (!mem_ce_n && !mem_oe_n) begin
        rd++;
        chk(mem_we_n, "R3", "we high in read", mem_we_n, 1);
        chk(mem_lb_n == ~m[0] && mem_ub_n == ~m[1], "R3", "lane strobes",
            {mem_ub_n, mem_lb_n}, ~m);
        chk(mem_addr == a, "R10", "read address held", mem_addr, a);
      end
      if (poke && k == 2) begin req_valid = 1'b1; req_we = 1'b1; req_addr = ~a; end
      if (poke && k == 3) begin
        req_valid = 1'b0;
        chk(!req_ready, "R10", "busy not ready", req_ready, 0);
      end
      @(negedge clk);
      k++;
    end
    e = pat(a) & {{8{m[1]}}, {8{m[0]}}};
    chk(rd == E_RD55, "R3", "read strobe cycles", rd, E_RD55);
    chk(mem_oe_n, "R4", "valid after last read cycle", mem_oe_n, 1);
    chk(rsp_rdata == e, "R4", "read data", rsp_rdata, e);
    if (poke) begin
      for (int i = 0; i < 3; i++) begin
        @(negedge clk);
        chk(mem_ce_n && req_ready && !rsp_valid, "R10", "no extra access",
            {mem_ce_n, req_ready, rsp_valid}, 3'b110);
      end
    end
  endtask

  // starts at a falling edge with ready high, ends when ready again
  task automatic do_write(input logic [15:0] a, input logic [15:0] d,
                          input logic [1:0] m, input int exp_gap);
    int k = 1, lo = 0, gap = -1;
    bit held = 1'b0;
    chk(req_ready, "R2", "ready before write", req_ready, 1);
    req_valid = 1'b1; req_we = 1'b1; req_addr = a; req_wdata = d; req_bmask = m;
    @(negedge clk);
    req_valid = 1'b0;
    chk(mem_we_n && mem_addr == a, "R6", "address set with we high", mem_addr, a);
    chk(!rsp_valid, "R4", "valid single cycle", rsp_valid, 0);
    while (!req_ready && k < 100) begin
      if (mem_dq_oe && gap < 0) gap = k;
      if (!mem_we_n) begin
        lo++;
        chk(!mem_ce_n && mem_addr == a, "R6", "address stable during pulse", mem_addr, a);
        chk(mem_dq_oe && mem_dq_out == d, "R7", "data during pulse", mem_dq_out, d);
        chk(mem_lb_n == ~m[0] && mem_ub_n == ~m[1], "R5", "write lanes",
            {mem_ub_n, mem_lb_n}, ~m);
      end else if (lo > 0 && !held) begin
        held = 1'b1;
        chk(mem_dq_oe && mem_dq_out == d, "R7", "data hold after pulse", mem_dq_out, d);
      end
      @(negedge clk);
      k++;
    end
    chk(lo == E_WP55, "R5", "write pulse cycles", lo, E_WP55);
    chk(gap == exp_gap, "R8", "cycles to data drive", gap, exp_gap);
  endtask

  task automatic g70_read();
    int rd = 0, k = 0;
    v70 = 1'b1; we70 = 1'b0;
    @(negedge clk);
    v70 = 1'b0;
    while (!rv70 && k < 100) begin
      if (!ce70 && !oe70) rd++;
      @(negedge clk); k++;
    end
    chk(rd == E_RD70, "R9", "70ns read cycles", rd, E_RD70);
  endtask

  task automatic g70_write();
    int lo = 0, k = 0;
    v70 = 1'b1; we70 = 1'b1;
    @(negedge clk);
    v70 = 1'b0;
    while (!rdy70 && k < 100) begin
      if (!wen70) lo++;
      @(negedge clk); k++;
    end
    chk(lo == E_WP70, "R9", "70ns write pulse", lo, E_WP70);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    do_read(16'h1234, 2'b11, 1'b0);
    @(negedge clk);
    do_read(16'hA0F1, 2'b01, 1'b0);
    @(negedge clk);
    do_read(16'h7E02, 2'b10, 1'b0);
    @(negedge clk);
    @(negedge clk);
    do_write(16'h0300, 16'hC3A5, 2'b11, 1);
    do_write(16'h0301, 16'h5AF0, 2'b01, 1);
    do_write(16'hFFFF, 16'h0F0F, 2'b10, 1);
    do_read(16'h4455, 2'b11, 1'b0);
    do_write(16'h4455, 16'h9999, 2'b11, E_OHZ55);
    do_read(16'h0001, 2'b11, 1'b1);
    g70_read();
    @(negedge clk);
    g70_write();
    @(negedge clk);
    t_reset();
    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(CLK_P * 100000);
    if (!finished) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog R1 actual=%0d expected=%0d", 0, 1);
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end
endmodule